// File: doc/BRIEF.md
# Pattern Sequencer Controller

This block is a small program-driven controller that decides the order in which clock patterns play. It reads 32-bit instruction words from a local code memory and steps through them with a program counter. It keeps a hardware stack of active loops and a separate stack of return addresses. When it reaches an execute instruction, it passes a pattern offset and a repeat count to an external pattern playback engine. It then waits until that engine reports that the pattern has finished.

A host fills the code memory through a valid/ready write port, and can do so only while the controller is idle. A one-cycle start pulse begins execution at address 0. The program runs until one of three things happens: an exit instruction, a stop request, or a fault. A fault is a stack overflow, a stack underflow, or the undefined opcode. After a fault the controller returns to idle with the error flag raised.

The pattern command is a valid/ready interface. Once the controller raises `cmd_valid`, it holds the offset and count steady until the engine accepts them with `cmd_ready`. The engine may apply back-pressure for any number of cycles. After each acceptance the controller drives no new command until the engine pulses `pat_done`.

Top module: `patseq_ctrl`

## Requirements
- R1: An instruction word has its opcode in bits 30..28, a 16-bit count in bits 26..11 and an 11-bit address in bits 10..0. Opcode 001 (execute) issues one pattern command, with `cmd_offset` set to the address field and `cmd_count` set to the count field. An execute instruction whose count is 0 issues no command, and execution moves on to the next word.
- R2: While `cmd_valid` is high and `cmd_ready` is low, the offset and count stay unchanged. After a command is accepted, no further command is raised until `pat_done` has pulsed.
- R3: Opcode 010 opens a counted loop with a count N of 1 or more. Opcode 011 closes the innermost open loop. The body runs N times, and counted loops nest.
- R4: Opcode 010 with N = 0 skips forward to the word after its matching 011. Any 010 or 100 words met during the skip open a nesting level that needs its own 011.
- R5: Opcode 100 opens a loop that never ends. Its closing 011 always jumps back to the first word of the body.
- R6: Opcode 101 calls the subroutine at the code address in bits 10..0. Opcode 110 returns to the word after the most recent call. Calls nest.
- R7: Opcode 000 ends the program. `busy` falls and `err` stays low.
- R8: Each of the following halts the program, drops `busy` and sets `err`:
  - opening a ninth loop or making a ninth call while the 8-entry stack is full;
  - closing a loop or returning when that stack is empty;
  - opcode 111.
  
  `err` stays set until the next start.
- R9: `ld_ready` is high only while the controller is idle, so no write reaches the code memory during a run.
- R10: `start` is acted on only when idle, and execution begins at address 0. A `stop` pulse takes effect at the next instruction boundary, after any accepted pattern has reported `pat_done`, and the controller then goes idle.
- R11: After reset, `busy`, `err` and `cmd_valid` are low and `ld_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Host write request to code memory |
| ld_ready | output | 1 | Code memory accepts a write (idle only) |
| ld_addr | input | 11 | Code memory write address |
| ld_data | input | 32 | Instruction word to write |
| start | input | 1 | One-cycle start pulse |
| stop | input | 1 | One-cycle stop request |
| cmd_valid | output | 1 | Pattern command present |
| cmd_ready | input | 1 | Playback engine accepts the command |
| cmd_offset | output | 11 | Pattern memory offset |
| cmd_count | output | 16 | Number of pattern repetitions |
| pat_done | input | 1 | Playback engine finished the accepted pattern |
| busy | output | 1 | Program running |
| err | output | 1 | Last run ended on a fault |

## Verification
The first program nests a counted loop inside another and makes a call that itself makes a call, so a wrong loop count or a wrong return address changes the command stream. The second program wraps a nested counted loop and an infinite loop inside a zero-count loop, which separates a correct skip that counts nesting from one that stops at the first closing word. A third program loops forever and is halted by a stop request while the host tries to write. Running it again shows whether the write landed and whether the stop waited for the pattern to finish. Short faulting programs then cover both stacks overflowing and underflowing and the undefined opcode, and a final rerun shows that start clears the error flag.

// File: rtl/patseq_pkg.sv
package patseq_pkg;
  localparam int WORD_W  = 32;
  localparam int OPC_LSB = 28;
  localparam int REP_LSB = 11;
  localparam int REP_W   = 16;
  localparam int ADR_W   = 11;

  typedef enum logic [2:0] {
    OP_EXIT    = 3'd0,
    OP_EXEC    = 3'd1,
    OP_LOOP    = 3'd2,
    OP_LOOPEND = 3'd3,
    OP_LOOPINF = 3'd4,
    OP_JSR     = 3'd5,
    OP_RETURN  = 3'd6,
    OP_BAD     = 3'd7
  } opcode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DEC, S_ISSUE, S_WAIT, S_SKIPF, S_SKIPD
  } state_e;
endpackage

// File: rtl/patseq_code_ram.sv
module patseq_code_ram #(
  parameter int AW = 11,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/patseq_stack.sv
module patseq_stack #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic         pop,
  input  logic         upd,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] cnt;
  logic [AW-1:0] top_idx;

  assign empty   = (cnt == '0);
  assign full    = (cnt == PW'(DEPTH));
  assign top_idx = cnt[AW-1:0] - AW'(1);
  assign top     = mem[top_idx];

  always_ff @(posedge clk) begin
    if (!rst_n || clr)          cnt <= '0;
    else if (push && !full)     cnt <= cnt + PW'(1);
    else if (pop && !empty)     cnt <= cnt - PW'(1);
  end

  always_ff @(posedge clk) begin
    if (push && !full)          mem[cnt[AW-1:0]] <= din;
    else if (upd && !empty)     mem[top_idx]     <= din;
  end
endmodule

// File: rtl/patseq_ctrl.sv
module patseq_ctrl
  import patseq_pkg::*;
#(
  parameter int CODE_AW    = 11,
  parameter int LOOP_DEPTH = 8,
  parameter int CALL_DEPTH = 8,
  parameter int SKIP_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_valid,
  output logic               ld_ready,
  input  logic [CODE_AW-1:0] ld_addr,
  input  logic [WORD_W-1:0]  ld_data,
  input  logic               start,
  input  logic               stop,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [ADR_W-1:0]   cmd_offset,
  output logic [REP_W-1:0]   cmd_count,
  input  logic               pat_done,
  output logic               busy,
  output logic               err
);
  typedef struct packed {
    logic               inf;
    logic [CODE_AW-1:0] body;
    logic [REP_W-1:0]   cnt;
  } lent_t;
  localparam int LE_W = $bits(lent_t);

  state_e              state_q, state_n;
  logic [CODE_AW-1:0]  pc_q, pc_n, pc_inc, tgt;
  logic [SKIP_W-1:0]   skip_q, skip_n;
  logic                err_n, stop_pend, clr;
  logic [WORD_W-1:0]   instr;
  opcode_e             op;
  logic [REP_W-1:0]    rep;
  logic [ADR_W-1:0]    off_n, off_q;
  logic [REP_W-1:0]    cnt_n, cnt_q;
  logic                unused_bits;

  lent_t               l_din, l_top;
  logic                l_push, l_pop, l_upd, l_empty, l_full;
  logic [CODE_AW-1:0]  r_din, r_top;
  logic                r_push, r_pop, r_empty, r_full;

  assign op          = opcode_e'(instr[OPC_LSB +: 3]);
  assign rep         = instr[REP_LSB +: REP_W];
  assign tgt         = CODE_AW'(instr[ADR_W-1:0]);
  assign pc_inc      = pc_q + CODE_AW'(1);
  assign unused_bits = ^{instr[31], instr[27]};

  patseq_code_ram #(.AW(CODE_AW), .DW(WORD_W)) u_ram (
    .clk(clk), .we(ld_valid && ld_ready), .waddr(ld_addr), .wdata(ld_data),
    .raddr(pc_q), .rdata(instr)
  );

  patseq_stack #(.W(LE_W), .DEPTH(LOOP_DEPTH)) u_loop_stk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(l_push), .pop(l_pop), .upd(l_upd),
    .din(l_din), .top(l_top), .empty(l_empty), .full(l_full)
  );

  patseq_stack #(.W(CODE_AW), .DEPTH(CALL_DEPTH)) u_call_stk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(r_push), .pop(r_pop), .upd(1'b0),
    .din(r_din), .top(r_top), .empty(r_empty), .full(r_full)
  );

  always_comb begin
    state_n = state_q;
    pc_n    = pc_q;
    skip_n  = skip_q;
    err_n   = err;
    off_n   = off_q;
    cnt_n   = cnt_q;
    clr     = 1'b0;
    l_push  = 1'b0; l_pop = 1'b0; l_upd = 1'b0; l_din = l_top;
    r_push  = 1'b0; r_pop = 1'b0; r_din = pc_inc;
    unique case (state_q)
      S_IDLE: if (start) begin
        pc_n = '0; err_n = 1'b0; clr = 1'b1; state_n = S_FETCH;
      end
      S_FETCH: state_n = stop_pend ? S_IDLE : S_DEC;
      S_DEC: begin
        state_n = S_FETCH;
        unique case (op)
          OP_EXIT: state_n = S_IDLE;
          OP_EXEC:
            if (rep == '0) pc_n = pc_inc;
            else begin
              off_n = instr[ADR_W-1:0]; cnt_n = rep; state_n = S_ISSUE;
            end
          OP_LOOP, OP_LOOPINF:
            if (op == OP_LOOP && rep == '0) begin
              skip_n = '0; pc_n = pc_inc; state_n = S_SKIPF;
            end else if (l_full) begin
              err_n = 1'b1; state_n = S_IDLE;
            end else begin
              l_push     = 1'b1;
              l_din.inf  = (op == OP_LOOPINF);
              l_din.body = pc_inc;
              l_din.cnt  = rep;
              pc_n       = pc_inc;
            end
          OP_LOOPEND:
            if (l_empty) begin
              err_n = 1'b1; state_n = S_IDLE;
            end else if (l_top.inf) pc_n = l_top.body;
            else if (l_top.cnt > REP_W'(1)) begin
              l_upd = 1'b1; l_din.cnt = l_top.cnt - REP_W'(1); pc_n = l_top.body;
            end else begin
              l_pop = 1'b1; pc_n = pc_inc;
            end
          OP_JSR:
            if (r_full) begin
              err_n = 1'b1; state_n = S_IDLE;
            end else begin
              r_push = 1'b1; pc_n = tgt;
            end
          OP_RETURN:
            if (r_empty) begin
              err_n = 1'b1; state_n = S_IDLE;
            end else begin
              r_pop = 1'b1; pc_n = r_top;
            end
          default: begin
            err_n = 1'b1; state_n = S_IDLE;
          end
        endcase
      end
      S_ISSUE: if (cmd_ready) state_n = S_WAIT;
      S_WAIT: if (pat_done) begin
        pc_n = pc_inc; state_n = S_FETCH;
      end
      S_SKIPF: state_n = S_SKIPD;
      S_SKIPD: begin
        pc_n    = pc_inc;
        state_n = S_SKIPF;
        if (op == OP_LOOP || op == OP_LOOPINF) skip_n = skip_q + SKIP_W'(1);
        else if (op == OP_LOOPEND) begin
          if (skip_q == '0) state_n = S_FETCH;
          else skip_n = skip_q - SKIP_W'(1);
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      pc_q      <= '0;
      skip_q    <= '0;
      err       <= 1'b0;
      stop_pend <= 1'b0;
      off_q     <= '0;
      cnt_q     <= '0;
    end else begin
      state_q   <= state_n;
      pc_q      <= pc_n;
      skip_q    <= skip_n;
      err       <= err_n;
      off_q     <= off_n;
      cnt_q     <= cnt_n;
      if (state_q == S_IDLE) stop_pend <= 1'b0;
      else if (stop)         stop_pend <= 1'b1;
    end
  end

  assign cmd_valid  = (state_q == S_ISSUE);
  assign cmd_offset = off_q;
  assign cmd_count  = cnt_q;
  assign busy       = (state_q != S_IDLE);
  assign ld_ready   = (state_q == S_IDLE);
endmodule

// File: rtl/patseq_ctrl_chk.sv
module patseq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [10:0] cmd_offset,
  input logic [15:0] cmd_count,
  input logic        busy,
  input logic        err
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_offset) && $stable(cmd_count));

  assert_one_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid);

  assert_nonzero_cnt_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_count != 16'd0);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);

  assert_start_runs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !err);

  assert_err_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
endmodule

bind patseq_ctrl patseq_ctrl_chk u_chk (.*);

// File: tb/patseq_ctrl_test.sv
module patseq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ld_valid = 1'b0, start = 1'b0, stop = 1'b0;
  logic        cmd_ready = 1'b0, pat_done = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic        ld_ready, cmd_valid, busy, err;
  logic [10:0] cmd_offset;
  logic [15:0] cmd_count;

  int compared = 0, mismatched = 0, accepted = 0;
  bit outstanding = 1'b0;
  logic [31:0] img [2**AW];
  int exp_off[$], exp_cnt[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  patseq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .start(start), .stop(stop),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_offset(cmd_offset),
    .cmd_count(cmd_count), .pat_done(pat_done), .busy(busy), .err(err)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic put(input int addr, input bit [2:0] op, input int n, input int a);
    logic [31:0] w;
    w = {1'b0, op, 1'b0, n[15:0], a[10:0]};
    img[addr] = w;
    @(negedge clk); ld_valid = 1'b1; ld_addr = addr[AW-1:0]; ld_data = w;
    @(negedge clk); ld_valid = 1'b0;
  endtask

  // Behavioural interpreter producing the expected command stream
  task automatic ref_run(input int maxcmd, output bit ferr);
    int pc, depth, k, op, n, a, o2;
    int lb[$], lc[$], rs[$];
    bit li[$];
    bit fin, go;
    pc = 0; fin = 1'b0; ferr = 1'b0;
    exp_off.delete(); exp_cnt.delete();
    for (int step = 0; step < 20000 && !fin; step++) begin
      op = int'(img[pc][30:28]); n = int'(img[pc][26:11]); a = int'(img[pc][10:0]);
      if (exp_off.size() >= maxcmd) fin = 1'b1;
      else case (op)
        0: fin = 1'b1;
        1: begin
          if (n != 0) begin exp_off.push_back(a); exp_cnt.push_back(n); end
          pc++;
        end
        2, 4: begin
          if (op == 2 && n == 0) begin
            depth = 0; go = 1'b1; pc++;
            while (go && pc < 2**AW) begin
              o2 = int'(img[pc][30:28]);
              pc++;
              if (o2 == 2 || o2 == 4) depth++;
              else if (o2 == 3) begin
                if (depth == 0) go = 1'b0; else depth--;
              end
            end
          end else if (lb.size() >= 8) begin
            ferr = 1'b1; fin = 1'b1;
          end else begin
            lb.push_back(pc + 1); lc.push_back(n); li.push_back(op == 4); pc++;
          end
        end
        3: begin
          if (lb.size() == 0) begin ferr = 1'b1; fin = 1'b1; end
          else begin
            k = lb.size() - 1;
            if (li[k]) pc = lb[k];
            else if (lc[k] > 1) begin lc[k] = lc[k] - 1; pc = lb[k]; end
            else begin
              void'(lb.pop_back()); void'(lc.pop_back()); void'(li.pop_back()); pc++;
            end
          end
        end
        5: begin
          if (rs.size() >= 8) begin ferr = 1'b1; fin = 1'b1; end
          else begin rs.push_back(pc + 1); pc = a; end
        end
        6: begin
          if (rs.size() == 0) begin ferr = 1'b1; fin = 1'b1; end
          else pc = rs.pop_back();
        end
        default: begin ferr = 1'b1; fin = 1'b1; end
      endcase
    end
  endtask

  task automatic wait_idle(input string req);
    int t;
    t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    check(!busy, req, int'(busy), 0);
  endtask

  task automatic run_prog(input int maxcmd, input int stop_after, input string req);
    bit ferr;
    int base, total;
    ref_run(maxcmd, ferr);
    total = exp_off.size();
    base = accepted;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy || (total == 0 && !ferr), "R10 start", int'(busy), 1);
    if (stop_after > 0) begin
      wait (accepted >= base + stop_after);
      @(negedge clk); stop = 1'b1;
      @(negedge clk); stop = 1'b0;
      wait_idle(req);
      check(accepted - base == stop_after, {req, " stop at boundary R10"}, accepted - base, stop_after);
      check(err == 1'b0, {req, " err after stop"}, int'(err), 0);
      exp_off.delete(); exp_cnt.delete();
    end else begin
      wait_idle(req);
      check(accepted - base == total, {req, " command total"}, accepted - base, total);
      check(err == ferr, {req, " err flag"}, int'(err), int'(ferr));
    end
  endtask

  // Pattern playback engine model with back-pressure
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        repeat (accepted % 3) @(negedge clk);
        cmd_ready = 1'b1;
        if (exp_off.size() == 0)
          check(1'b0, "R1 unexpected command", int'(cmd_offset), -1);
        else begin
          check(int'(cmd_offset) == exp_off[0], "R1 offset", int'(cmd_offset), exp_off[0]);
          check(int'(cmd_count) == exp_cnt[0], "R1 count", int'(cmd_count), exp_cnt[0]);
          void'(exp_off.pop_front()); void'(exp_cnt.pop_front());
        end
        accepted++;
        @(negedge clk); cmd_ready = 1'b0; outstanding = 1'b1;
        repeat (2 + accepted % 2) @(negedge clk);
        pat_done = 1'b1;
        @(negedge clk); pat_done = 1'b0; outstanding = 1'b0;
      end
    end
  end

  // Per-clock comparison of handshake and load-port rules
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rst_n) begin
        check(!(outstanding && cmd_valid), "R2 command while pattern outstanding", int'(cmd_valid), 0);
        check(ld_ready == !busy, "R9 load ready only when idle", int'(ld_ready), int'(!busy));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 2**AW; i++) img[i] = 32'd0;
    repeat (4) @(negedge clk);
    // R11 reset state
    check(busy == 1'b0, "R11 busy", int'(busy), 0);
    check(err == 1'b0, "R11 err", int'(err), 0);
    check(cmd_valid == 1'b0, "R11 cmd_valid", int'(cmd_valid), 0);
    check(ld_ready == 1'b1, "R11 ld_ready", int'(ld_ready), 1);
    rst_n = 1'b1;

    // Nested counted loops and nested calls: R3 R6 R7
    put(0, 3'd2, 3, 0);  put(1, 3'd1, 5, 10); put(2, 3'd2, 2, 0);
    put(3, 3'd1, 1, 20); put(4, 3'd3, 0, 0);  put(5, 3'd3, 0, 0);
    put(6, 3'd5, 0, 20); put(7, 3'd0, 0, 0);
    put(20, 3'd1, 7, 30); put(21, 3'd5, 0, 24); put(22, 3'd6, 0, 0);
    put(24, 3'd1, 2, 31); put(25, 3'd6, 0, 0);
    run_prog(1000, 0, "R3 R6 R7");

    // Zero-count loop skip with nesting, zero-count execute: R4 R1
    put(0, 3'd2, 0, 0); put(1, 3'd2, 4, 0); put(2, 3'd1, 1, 50);
    put(3, 3'd3, 0, 0); put(4, 3'd4, 0, 0); put(5, 3'd3, 0, 0);
    put(6, 3'd3, 0, 0); put(7, 3'd1, 0, 60); put(8, 3'd1, 9, 61);
    put(9, 3'd0, 0, 0);
    run_prog(1000, 0, "R4");

    // Infinite loop, stopped; write attempt during run: R5 R9 R10
    put(0, 3'd4, 0, 0); put(1, 3'd1, 2, 40); put(2, 3'd1, 3, 41);
    put(3, 3'd3, 0, 0); put(4, 3'd0, 0, 0);
    fork
      run_prog(100, 6, "R5 R10");
      begin
        repeat (6) @(negedge clk);
        ld_valid = 1'b1; ld_addr = 11'd1; ld_data = 32'd0;
        repeat (4) @(negedge clk);
        ld_valid = 1'b0;
      end
    join
    run_prog(100, 5, "R9 rerun unchanged");

    // Faults: R8
    put(0, 3'd5, 0, 0);
    run_prog(1000, 0, "R8 call overflow");
    put(0, 3'd3, 0, 0);
    run_prog(1000, 0, "R8 loop underflow");
    put(0, 3'd6, 0, 0);
    run_prog(1000, 0, "R8 return underflow");
    put(0, 3'd1, 1, 7); put(1, 3'd7, 0, 0);
    run_prog(1000, 0, "R8 undefined opcode");
    for (int i = 0; i < 9; i++) put(i, 3'd2, 1, 0);
    run_prog(1000, 0, "R8 loop overflow");

    // Restart clears the error: R8
    put(0, 3'd2, 2, 0); put(1, 3'd1, 4, 11); put(2, 3'd3, 0, 0); put(3, 3'd0, 0, 0);
    run_prog(1000, 0, "R8 cleared by start");

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule